// File: doc/BRIEF.md
# Circular Queue Manager for Message Frame Addresses

This block keeps four circular queues of 32-bit message frame addresses in external memory. One aligned region, set by a base register and an encoded size code, holds all four queues back to back. Each queue has a head and a tail pointer. The local processor sets up the base, the control word and the pointers through a small register port.

A host reaches the queues through two queue ports, inbound and outbound. The host never sees a pointer. A read on a port pops one entry, and a write on a port pushes one. For each pop or push the block issues one memory access through a request/ready port and moves the matching pointer. A pop from an empty queue returns all-ones and makes no memory access. A push into a full queue is dropped and sets a sticky overflow bit. Level outputs report whether each of the two post queues holds any entries, so an interrupt unit can use them directly.

Top module: `cq_mgr`

## Requirements
- R1: After reset, every register reads zero, host_ack and mem_req are low, and both not-empty outputs and both overflow outputs are low.
- R2: Register 0 holds the region base. A write whose low 20 bits are not all zero is ignored. An aligned write is stored and reads back.
- R3: Register 1 is control: bit 0 is enable and bits [7:2] are the size code. A write whose size code is not 0x02, 0x04, 0x08, 0x10 or 0x20 is ignored as a whole.
- R4: Queue k (0 inbound free, 1 inbound post, 2 outbound free, 3 outbound post) starts at base + k*code*2048. A push writes memory at the head address, and a pop reads memory at the tail address.
- R5: A pointer advances by 4 after its access. When it reaches the end of its own queue region it wraps to the start of that region.
- R6: host_sel=0 selects the inbound port, where a read pops queue 0 and a write pushes queue 1. host_sel=1 selects the outbound port, where a read pops queue 3 and a write pushes queue 2.
- R7: A pop from a queue whose head equals its tail returns 0xFFFFFFFF, leaves the tail unchanged and makes no memory access.
- R8: A push whose advanced head would equal the tail makes no memory write and leaves the head unchanged. It sets sticky status bit 0 (queue 1) or bit 1 (queue 2) in register 2, which is cleared by writing 1 to that bit. The same bits drive ipost_ovf and ofree_ovf.
- R9: While enable is clear, a host read returns 0xFFFFFFFF, a host write has no effect, and no memory access starts.
- R10: ipost_nempty and opost_nempty equal (head != tail) of queues 1 and 3 in every cycle, including after register writes to the pointers.
- R11: host_ack is a one-cycle pulse. mem_req stays high with stable address and direction until mem_ready, and the ack follows in the next cycle.
- R12: Register 8+2k holds the head of queue k and register 9+2k holds its tail. Both are writable and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Local register write strobe |
| reg_addr | input | 4 | Local register index |
| reg_wdata | input | 32 | Local register write data |
| reg_rdata | output | 32 | Local register read data (combinational) |
| host_req | input | 1 | Host queue port request, held until ack |
| host_we | input | 1 | 1 push, 0 pop |
| host_sel | input | 1 | 0 inbound port, 1 outbound port |
| host_wdata | input | 32 | Frame address to push |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Popped frame address, valid with ack |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory access done |
| mem_rdata | input | 32 | Memory read data, valid with ready |
| ipost_nempty | output | 1 | Inbound post queue holds entries |
| opost_nempty | output | 1 | Outbound post queue holds entries |
| ipost_ovf | output | 1 | Sticky inbound post overflow |
| ofree_ovf | output | 1 | Sticky outbound free overflow |

## Verification
A wrong pointer or a wrong region calculation shows up on the next port operation, either as a mem_addr that differs from the expected head or tail address or as a pointer that reads back wrong in the same cycle the access finishes. A wrong full or empty decision shows up at once. The bench sees a memory access where none should occur, an all-ones word where data should come back, or an overflow bit that fails to set. The not-empty outputs follow the pointers combinationally, so a mismatch between them and the pointers can be seen in the cycle right after a pointer write. The bench therefore checks each pointer, each memory address and each status bit right after the operation that should change it.

// File: rtl/cq_pkg.sv
package cq_pkg;

    typedef enum logic [1:0] {
        Q_IFREE = 2'd0,
        Q_IPOST = 2'd1,
        Q_OFREE = 2'd2,
        Q_OPOST = 2'd3
    } qid_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } fsm_e;

    // legal size codes are single powers of two from 2 to 32
    function automatic logic size_code_ok(input logic [31:0] c);
        return (c == 32'd2) || (c == 32'd4) || (c == 32'd8) ||
               (c == 32'd16) || (c == 32'd32);
    endfunction

endpackage

// File: rtl/cq_region.sv
module cq_region #(
    parameter int ADDR_W     = 32,
    parameter int CODE_W     = 6,
    parameter int UNIT_SHIFT = 11,
    parameter int NQ         = 4
) (
    input  logic [ADDR_W-1:0]          base_i,
    input  logic [CODE_W-1:0]          code_i,
    output logic [NQ-1:0][ADDR_W-1:0]  start_o,
    output logic [NQ-1:0][ADDR_W-1:0]  end_o
);
    logic [ADDR_W-1:0] span;
    assign span = ADDR_W'(code_i) << UNIT_SHIFT;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign start_o[g] = base_i + ADDR_W'(g) * span;
        assign end_o[g]   = base_i + ADDR_W'(g + 1) * span;
    end
endmodule

// File: rtl/cq_ring.sv
module cq_ring #(
    parameter int ADDR_W      = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-1:0] head_i,
    input  logic [ADDR_W-1:0] tail_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    output logic [ADDR_W-1:0] head_step_o,
    output logic [ADDR_W-1:0] tail_step_o,
    output logic              empty_o,
    output logic              full_o
);
    function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] p);
        logic [ADDR_W-1:0] n;
        n = p + ADDR_W'(ENTRY_BYTES);
        return (n == end_i) ? start_i : n;
    endfunction

    assign head_step_o = step(head_i);
    assign tail_step_o = step(tail_i);
    assign empty_o     = (head_i == tail_i);
    assign full_o      = (head_step_o == tail_i);
endmodule

// File: rtl/cq_mgr.sv
module cq_mgr
    import cq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int ALIGN_BITS  = 20,
    parameter int UNIT_SHIFT  = 11,
    parameter int ENTRY_BYTES = 4,
    parameter int CODE_W      = 6,
    parameter int REG_AW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ipost_nempty,
    output logic              opost_nempty,
    output logic              ipost_ovf,
    output logic              ofree_ovf
);
    localparam int NQ        = 4;
    localparam int QW        = $clog2(NQ);
    localparam int CODE_LSB  = 2;
    localparam logic [REG_AW-1:0] RA_BASE = REG_AW'(0);
    localparam logic [REG_AW-1:0] RA_CTRL = REG_AW'(1);
    localparam logic [REG_AW-1:0] RA_STAT = REG_AW'(2);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [ADDR_W-1:0]         base;
        logic                      en;
        logic [CODE_W-1:0]         code;
        logic [1:0]                ovf;
        logic [NQ-1:0][ADDR_W-1:0] head;
        logic [NQ-1:0][ADDR_W-1:0] tail;
        fsm_e                      st;
        logic [QW-1:0]             q;
        logic                      push;
        logic                      mreq;
        logic [ADDR_W-1:0]         maddr;
        logic [DATA_W-1:0]         mdata;
        logic                      ack;
        logic [DATA_W-1:0]         rdata;
    } state_t;

    state_t s_q, s_d;

    logic [NQ-1:0][ADDR_W-1:0] q_start, q_end, head_step, tail_step;
    logic [NQ-1:0]             q_empty, q_full;
    logic                      ctrl_en;
    logic [ADDR_W-1:0]         base_w;

    assign ctrl_en = s_q.en;
    assign base_w  = s_q.base;

    cq_region #(
        .ADDR_W(ADDR_W), .CODE_W(CODE_W), .UNIT_SHIFT(UNIT_SHIFT), .NQ(NQ)
    ) i_region (
        .base_i (s_q.base),
        .code_i (s_q.code),
        .start_o(q_start),
        .end_o  (q_end)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_ring
        cq_ring #(.ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)) i_ring (
            .head_i     (s_q.head[g]),
            .tail_i     (s_q.tail[g]),
            .start_i    (q_start[g]),
            .end_i      (q_end[g]),
            .head_step_o(head_step[g]),
            .tail_step_o(tail_step[g]),
            .empty_o    (q_empty[g]),
            .full_o     (q_full[g])
        );
    end

    // queue picked by the current host request
    logic [QW-1:0] push_q, pop_q;
    assign push_q = host_sel ? QW'(Q_OFREE) : QW'(Q_IPOST);
    assign pop_q  = host_sel ? QW'(Q_OPOST) : QW'(Q_IFREE);

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;

        // local register writes
        if (reg_we) begin
            if (reg_addr == RA_BASE) begin
                if (reg_wdata[ALIGN_BITS-1:0] == '0)
                    s_d.base = reg_wdata[ADDR_W-1:0];
            end else if (reg_addr == RA_CTRL) begin
                if (size_code_ok(32'(reg_wdata[CODE_LSB +: CODE_W]))) begin
                    s_d.en   = reg_wdata[0];
                    s_d.code = reg_wdata[CODE_LSB +: CODE_W];
                end
            end else if (reg_addr == RA_STAT) begin
                s_d.ovf = s_q.ovf & ~reg_wdata[1:0];
            end else if (reg_addr[REG_AW-1]) begin
                if (reg_addr[0])
                    s_d.tail[reg_addr[QW:1]] = reg_wdata[ADDR_W-1:0];
                else
                    s_d.head[reg_addr[QW:1]] = reg_wdata[ADDR_W-1:0];
            end
        end

        // host queue port sequencing
        case (s_q.st)
            ST_IDLE: begin
                if (host_req && !s_q.ack) begin
                    if (!s_q.en) begin
                        s_d.ack   = 1'b1;
                        s_d.rdata = host_we ? '0 : ALL_ONES;
                    end else if (host_we) begin
                        if (q_full[push_q]) begin
                            s_d.ack   = 1'b1;
                            s_d.rdata = '0;
                            if (push_q == QW'(Q_IPOST)) s_d.ovf[0] = 1'b1;
                            else                        s_d.ovf[1] = 1'b1;
                        end else begin
                            s_d.st    = ST_MEM;
                            s_d.q     = push_q;
                            s_d.push  = 1'b1;
                            s_d.mreq  = 1'b1;
                            s_d.maddr = s_q.head[push_q];
                            s_d.mdata = host_wdata;
                        end
                    end else begin
                        if (q_empty[pop_q]) begin
                            s_d.ack   = 1'b1;
                            s_d.rdata = ALL_ONES;
                        end else begin
                            s_d.st    = ST_MEM;
                            s_d.q     = pop_q;
                            s_d.push  = 1'b0;
                            s_d.mreq  = 1'b1;
                            s_d.maddr = s_q.tail[pop_q];
                        end
                    end
                end
            end
            ST_MEM: begin
                if (mem_ready) begin
                    s_d.st   = ST_IDLE;
                    s_d.mreq = 1'b0;
                    s_d.ack  = 1'b1;
                    if (s_q.push) begin
                        s_d.rdata       = '0;
                        s_d.head[s_q.q] = head_step[s_q.q];
                    end else begin
                        s_d.rdata       = mem_rdata;
                        s_d.tail[s_q.q] = tail_step[s_q.q];
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // local register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_BASE) begin
            reg_rdata = DATA_W'(s_q.base);
        end else if (reg_addr == RA_CTRL) begin
            reg_rdata = DATA_W'({s_q.code, 1'b0, s_q.en});
        end else if (reg_addr == RA_STAT) begin
            reg_rdata = DATA_W'(s_q.ovf);
        end else if (reg_addr[REG_AW-1]) begin
            reg_rdata = reg_addr[0] ? DATA_W'(s_q.tail[reg_addr[QW:1]])
                                    : DATA_W'(s_q.head[reg_addr[QW:1]]);
        end
    end

    assign host_ack     = s_q.ack;
    assign host_rdata   = s_q.rdata;
    assign mem_req      = s_q.mreq;
    assign mem_we       = s_q.push;
    assign mem_addr     = s_q.maddr;
    assign mem_wdata    = s_q.mdata;
    assign ipost_nempty = !q_empty[Q_IPOST];
    assign opost_nempty = !q_empty[Q_OPOST];
    assign ipost_ovf    = s_q.ovf[0];
    assign ofree_ovf    = s_q.ovf[1];

endmodule

// File: rtl/cq_mgr_chk.sv
module cq_mgr_chk #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              en,
    input logic [ADDR_W-1:0] base
);
    // R11: completion is a single-cycle pulse
    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R11: pending memory request holds its address and direction
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: ready ends the request and produces the ack next cycle
    assert_mem_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (host_ack && !mem_req));

    // R2: the stored base never carries low address bits
    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        base[ALIGN_BITS-1:0] == '0);

    // R9: a memory access only starts while the queues are enabled
    assert_no_mem_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(en));
endmodule

bind cq_mgr cq_mgr_chk #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) i_cq_mgr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_ack (host_ack),
    .mem_req  (mem_req),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .en       (ctrl_en),
    .base     (base_w)
);

// File: tb/test_cq_mgr.sv
module test_cq_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [31:0] BASE = 32'h0030_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_req = 1'b0, host_we = 1'b0, host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ipost_nempty, opost_nempty, ipost_ovf, ofree_ovf;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] mem_m [logic [31:0]];
    int          acc_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_waddr = '0, last_wdata = '0;
    int          wait_c = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cq_mgr i_cq_mgr (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_req(host_req), .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .ipost_nempty(ipost_nempty), .opost_nempty(opost_nempty),
        .ipost_ovf(ipost_ovf), .ofree_ovf(ofree_ovf)
    );

    // memory responder: one wait cycle, then a one-cycle ready
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
            end else if (mem_req) begin
                if (wait_c == 1) begin
                    wait_c = 0;
                    mem_ready = 1'b1;
                    acc_cnt++;
                    if (mem_we) begin
                        mem_m[mem_addr] = mem_wdata;
                        wr_cnt++;
                        last_waddr = mem_addr;
                        last_wdata = mem_wdata;
                    end else begin
                        mem_rdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 32'hDEAD_0000;
                    end
                end else begin
                    wait_c++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic rw(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rr(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic host_op(input logic sel, input logic we, input logic [31:0] wd,
                           output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_sel = sel; host_we = we; host_wdata = wd;
        do @(negedge clk); while (!host_ack);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    function automatic logic [3:0] hreg(input int k); return 4'(8 + 2*k); endfunction
    function automatic logic [3:0] treg(input int k); return 4'(9 + 2*k); endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 16; a++) begin
            rr(4'(a), v);
            chk("R1 register zero after reset", v, 32'h0);
        end
        chk("R1 ack low", {31'b0, host_ack}, 32'h0);
        chk("R1 mem_req low", {31'b0, mem_req}, 32'h0);
        chk("R1 status outputs low",
            {28'b0, ipost_nempty, opost_nempty, ipost_ovf, ofree_ovf}, 32'h0);
    endtask

    task automatic t_base();
        logic [31:0] v;
        rw(4'd0, 32'h0032_3456);
        rr(4'd0, v);
        chk("R2 unaligned base ignored", v, 32'h0);
        rw(4'd0, BASE);
        rr(4'd0, v);
        chk("R2 aligned base stored", v, BASE);
    endtask

    task automatic t_ptr_init();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rw(hreg(k), BASE + 32'(k) * 32'h1000);
            rw(treg(k), BASE + 32'(k) * 32'h1000);
        end
        rw(hreg(3), 32'h0030_3008);
        rr(hreg(3), v);
        chk("R12 head pointer readback", v, 32'h0030_3008);
        rw(hreg(3), 32'h0030_3000);
        rr(treg(2), v);
        chk("R12 tail pointer readback", v, 32'h0030_2000);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int a0;
        a0 = acc_cnt;
        host_op(1'b0, 1'b0, 32'h0, v);
        chk("R9 disabled read gives all-ones", v, 32'hFFFF_FFFF);
        host_op(1'b1, 1'b1, 32'h7777_0000, v);
        rr(hreg(2), v);
        chk("R9 disabled write leaves head", v, 32'h0030_2000);
        chk("R9 disabled no memory access", 32'(acc_cnt), 32'(a0));
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        rw(4'd1, 32'h0000_000D);
        rr(4'd1, v);
        chk("R3 bad size code ignored", v, 32'h0);
        rw(4'd1, 32'h0000_0009);
        rr(4'd1, v);
        chk("R3 control stored", v, 32'h0000_0009);
    endtask

    task automatic t_empty_pop();
        logic [31:0] v;
        int a0;
        a0 = acc_cnt;
        host_op(1'b0, 1'b0, 32'h0, v);
        chk("R7 empty pop all-ones", v, 32'hFFFF_FFFF);
        chk("R7 empty pop no memory access", 32'(acc_cnt), 32'(a0));
        rr(treg(0), v);
        chk("R7 empty pop tail kept", v, BASE);
    endtask

    task automatic t_push();
        logic [31:0] v;
        host_op(1'b0, 1'b1, 32'hAAAA_0001, v);
        chk("R4 R6 inbound push address", last_waddr, 32'h0030_1000);
        chk("R6 inbound push data", last_wdata, 32'hAAAA_0001);
        rr(hreg(1), v);
        chk("R5 inbound post head advanced", v, 32'h0030_1004);
        chk("R10 inbound post not-empty", {31'b0, ipost_nempty}, 32'h1);
        host_op(1'b1, 1'b1, 32'hBBBB_0002, v);
        chk("R4 R6 outbound push address", last_waddr, 32'h0030_2000);
        rr(hreg(2), v);
        chk("R6 outbound free head advanced", v, 32'h0030_2004);
    endtask

    task automatic t_pop();
        logic [31:0] v;
        mem_m[32'h0030_0000] = 32'h1234_0000;
        rw(hreg(0), 32'h0030_0004);
        host_op(1'b0, 1'b0, 32'h0, v);
        chk("R6 inbound pop data", v, 32'h1234_0000);
        rr(treg(0), v);
        chk("R4 inbound free tail advanced", v, 32'h0030_0004);
        mem_m[32'h0030_3000] = 32'h5678_0000;
        chk("R10 outbound post empty before", {31'b0, opost_nempty}, 32'h0);
        rw(hreg(3), 32'h0030_3004);
        chk("R10 outbound post not-empty after head write", {31'b0, opost_nempty}, 32'h1);
        host_op(1'b1, 1'b0, 32'h0, v);
        chk("R6 outbound pop data", v, 32'h5678_0000);
        @(negedge clk);
        chk("R10 outbound post empty after pop", {31'b0, opost_nempty}, 32'h0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        mem_m[32'h0030_0FFC] = 32'hCAFE_0003;
        rw(treg(0), 32'h0030_0FFC);
        rw(hreg(0), 32'h0030_0000);
        host_op(1'b0, 1'b0, 32'h0, v);
        chk("R5 pop at region end data", v, 32'hCAFE_0003);
        rr(treg(0), v);
        chk("R5 tail wraps to region start", v, 32'h0030_0000);
        rw(hreg(1), 32'h0030_1FFC);
        rw(treg(1), 32'h0030_1FFC);
        chk("R10 inbound post empty when equal", {31'b0, ipost_nempty}, 32'h0);
        host_op(1'b0, 1'b1, 32'h1111_0004, v);
        chk("R5 push at region end address", last_waddr, 32'h0030_1FFC);
        rr(hreg(1), v);
        chk("R5 head wraps to region start", v, 32'h0030_1000);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        int w0;
        rw(hreg(1), 32'h0030_1000);
        rw(treg(1), 32'h0030_1004);
        w0 = wr_cnt;
        host_op(1'b0, 1'b1, 32'h2222_0005, v);
        chk("R8 full push no write", 32'(wr_cnt), 32'(w0));
        rr(hreg(1), v);
        chk("R8 full push head kept", v, 32'h0030_1000);
        rr(4'd2, v);
        chk("R8 inbound post overflow bit", v, 32'h1);
        chk("R8 ipost_ovf output", {31'b0, ipost_ovf}, 32'h1);
        rw(4'd2, 32'h1);
        rr(4'd2, v);
        chk("R8 overflow cleared by write-one", v, 32'h0);
        rw(hreg(2), 32'h0030_2FFC);
        rw(treg(2), 32'h0030_2000);
        host_op(1'b1, 1'b1, 32'h3333_0006, v);
        chk("R8 wrapped full push no write", 32'(wr_cnt), 32'(w0));
        rr(4'd2, v);
        chk("R8 outbound free overflow bit", v, 32'h2);
        chk("R8 ofree_ovf output", {31'b0, ofree_ovf}, 32'h1);
    endtask

    task automatic t_resize();
        logic [31:0] v;
        rw(4'd1, 32'h0000_0011);
        rw(hreg(1), 32'h0030_2000);
        rw(treg(1), 32'h0030_2000);
        host_op(1'b0, 1'b1, 32'h4444_0007, v);
        chk("R4 size code 4 places queue 1", last_waddr, 32'h0030_2000);
    endtask

    task automatic t_disable_late();
        logic [31:0] v;
        int a0;
        mem_m[32'h0030_6000] = 32'h5555_0008;
        rw(treg(3), 32'h0030_6000);
        rw(hreg(3), 32'h0030_6004);
        rw(4'd1, 32'h0000_0010);
        a0 = acc_cnt;
        host_op(1'b1, 1'b0, 32'h0, v);
        chk("R9 disabled pop all-ones despite entries", v, 32'hFFFF_FFFF);
        rr(treg(3), v);
        chk("R9 disabled pop tail kept", v, 32'h0030_6000);
        chk("R9 disabled pop no memory access", 32'(acc_cnt), 32'(a0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base();
        t_ptr_init();
        t_disabled();
        t_ctrl();
        t_empty_pop();
        t_push();
        t_pop();
        t_wrap();
        t_overflow();
        t_resize();
        t_disable_late();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule